// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block shifts a destination operand left or right by a count and fills the vacated bit positions from a second source operand. It is a double-precision shift of the kind an integer execution unit performs. Each operation chooses one of two widths, 32-bit or 16-bit, and one of two directions. The result and the carry are registered once, so a result appears one clock after its operands are presented.

The count is always reduced to its five low bits. With a 32-bit width, every reduced count gives a well-formed funnel shift. With a 16-bit width, reduced counts of 16 to 31 lie outside the architecturally meaningful range. For these counts the block reproduces what a real processor does: it rotates the 32-bit word formed from the source (upper half) and the destination (lower half), and keeps the low half. Counts of 16 and above therefore exchange the roles of destination and source. A flag marks every 16-bit operation whose count falls in that range.

Top module: `dps_unit`

## Requirements
- R1: Only bits [4:0] of `count_in` take part; bits [7:5] have no effect on any output.
- R2: With `op_wide`=1 and `op_right`=0, for reduced count c in 1..31 the result is `(dst << c) | (src >> (32-c))`, truncated to 32 bits.
- R3: With `op_wide`=1 and `op_right`=1, for c in 1..31 the result is `(dst >> c) | (src << (32-c))`, truncated to 32 bits.
- R4: With `op_wide`=0 and `op_right`=0, for c in 1..15 the result is `(dst16 << c) | (src16 >> (16-c))`, truncated to 16 bits. Here dst16 and src16 are the low 16 bits of `dst_in` and `src_in`.
- R5: With `op_wide`=0 and c in 16..31, let d = c-16. The left result is `(src16 << d) | (dst16 >> (16-d))` and the right result is `(src16 >> d) | (dst16 << (16-d))`. Both are truncated to 16 bits, and d = 0 gives src16.
- R6: With `op_wide`=0 and `op_right`=1, for c in 1..15 the result is `(dst16 >> c) | (src16 << (16-c))`, truncated to 16 bits.
- R7: When c = 0, the result equals the destination (its low 16 bits in 16-bit mode) and `carry_out` equals `carry_in`.
- R8: For a nonzero count, the carry is set as follows.
  - Left shift: the carry is dst bit W-c, where W is the width (32 or 16).
  - Right shift: the carry is dst bit c-1.
  - 16-bit mode with c in 17..31: the left carry is src16 bit 32-c and the right carry is src16 bit c-17.
- R9: `undef_out` is 1 exactly when `op_wide`=0 and c > 15. It is always 0 in 32-bit mode.
- R10: In 16-bit mode, `res_out[31:16]` is zero and `dst_in[31:16]` and `src_in[31:16]` have no effect.
- R11: Outputs are registered. `out_valid` follows `in_valid` by one clock, and the output fields load only when `in_valid` is 1. Reset (active-low `rst_n`) clears `out_valid`, `res_out`, `carry_out` and `undef_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| op_wide | input | 1 | 1: 32-bit operation, 0: 16-bit operation |
| op_right | input | 1 | 1: shift right, 0: shift left |
| dst_in | input | 32 | Destination operand (shifted value) |
| src_in | input | 32 | Source operand (fill bits) |
| count_in | input | 8 | Shift count, reduced to bits [4:0] |
| carry_in | input | 1 | Carry kept when the reduced count is zero |
| out_valid | output | 1 | Result registers hold a new result |
| res_out | output | 32 | Shift result, zero-extended in 16-bit mode |
| carry_out | output | 1 | Last bit shifted out of the destination |
| undef_out | output | 1 | 16-bit operation with count in 16..31 |

## Verification
The properties assume that the control and operand inputs are known, non-X values in every cycle where `in_valid` is high. The count-zero and one-bit properties compare against operands taken one cycle earlier, so they also assume that the operands change only together with `in_valid`. The bench drives all inputs on the falling edge, holds them steady for a full cycle, and lowers `in_valid` between vectors. It deliberately places junk in the upper operand halves and in count bits [7:5] to exercise the no-effect requirements.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef struct packed {
      logic [31:0] res;
      logic        carry;
      logic        undef;
   } dps_out_t;
endpackage

// File: rtl/dps_wide_path.sv
module dps_wide_path #(
   parameter int W    = 32,
   parameter int SH_W = 5
) (
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic [SH_W-1:0] c,
   input  logic            right,
   output logic [W-1:0]    res,
   output logic            carry
);
   // One guard bit beyond the funnel catches the last bit shifted out.
   logic [2*W:0] lft;
   logic [2*W:0] rgt;

   always_comb begin
      lft = {1'b0, a, b} << c;
      rgt = {b, a, 1'b0} >> c;
      if (right) begin
         res   = rgt[W:1];
         carry = rgt[0];
      end else begin
         res   = lft[2*W-1:W];
         carry = lft[2*W];
      end
   end
endmodule

// File: rtl/dps_narrow_path.sv
module dps_narrow_path #(
   parameter int N    = 16,
   parameter int SH_W = 5
) (
   input  logic [N-1:0]    a,
   input  logic [N-1:0]    b,
   input  logic [SH_W-1:0] c,
   input  logic            right,
   output logic [N-1:0]    res,
   output logic            carry,
   output logic            undef
);
   localparam int XW = 2 * N;

   logic [XW-1:0]   x;
   logic [2*XW-1:0] rl;
   logic [2*XW-1:0] rr;

   // Rotate {src,dst} by the full reduced count; counts past N swap halves.
   always_comb begin
      x  = {b, a};
      rl = {x, x} << c;
      rr = {x, x} >> c;
      if (right) begin
         res   = rr[N-1:0];
         carry = rr[XW-1];
      end else begin
         res   = rl[XW+N-1:XW];
         carry = rl[XW+N];
      end
      undef = (c > SH_W'(N - 1));
   end
endmodule

// File: rtl/dps_unit.sv
module dps_unit #(
   parameter int WIDE_W    = 32,
   parameter int NARROW_W  = 16,
   parameter int CNT_W     = 8,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              op_wide,
   input  logic              op_right,
   input  logic [WIDE_W-1:0] dst_in,
   input  logic [WIDE_W-1:0] src_in,
   input  logic [CNT_W-1:0]  count_in,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [WIDE_W-1:0] res_out,
   output logic              carry_out,
   output logic              undef_out
);
   import dps_pkg::*;

   localparam int SH_W = $clog2(WIDE_W);

   if (WIDE_W != 2 * NARROW_W) begin : g_bad_ratio
      $error("dps_unit: WIDE_W must be twice NARROW_W");
   end
   if (CNT_W < SH_W) begin : g_bad_cnt
      $error("dps_unit: CNT_W too small for WIDE_W");
   end
   if (WIDE_W != 32) begin : g_bad_pkg
      $error("dps_unit: package result type is 32 bits wide");
   end

   logic [SH_W-1:0]     c;
   logic [WIDE_W-1:0]   w_res;
   logic                w_cy;
   logic [NARROW_W-1:0] n_res;
   logic                n_cy;
   logic                n_undef;
   dps_out_t            nxt;

   assign c = count_in[SH_W-1:0];

   dps_wide_path #(.W(WIDE_W), .SH_W(SH_W)) u_wide (
      .a(dst_in), .b(src_in), .c(c), .right(op_right),
      .res(w_res), .carry(w_cy)
   );

   if (NARROW_EN) begin : g_narrow
      dps_narrow_path #(.N(NARROW_W), .SH_W(SH_W)) u_narrow (
         .a(dst_in[NARROW_W-1:0]), .b(src_in[NARROW_W-1:0]), .c(c),
         .right(op_right), .res(n_res), .carry(n_cy), .undef(n_undef)
      );
   end else begin : g_no_narrow
      assign n_res   = '0;
      assign n_cy    = 1'b0;
      assign n_undef = 1'b0;
   end

   always_comb begin
      if (op_wide) begin
         nxt.res   = w_res;
         nxt.carry = w_cy;
         nxt.undef = 1'b0;
      end else begin
         nxt.res   = {{(WIDE_W-NARROW_W){1'b0}}, n_res};
         nxt.carry = n_cy;
         nxt.undef = n_undef;
      end
      if (c == '0) nxt.carry = carry_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_out   <= '0;
         carry_out <= 1'b0;
         undef_out <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_out   <= nxt.res;
            carry_out <= nxt.carry;
            undef_out <= nxt.undef;
         end
      end
   end
endmodule

// File: rtl/dps_unit_chk.sv
module dps_unit_chk #(
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16,
   parameter int CNT_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              op_wide,
   input logic              op_right,
   input logic [WIDE_W-1:0] dst_in,
   input logic [WIDE_W-1:0] src_in,
   input logic [CNT_W-1:0]  count_in,
   input logic              carry_in,
   input logic              out_valid,
   input logic [WIDE_W-1:0] res_out,
   input logic              carry_out,
   input logic              undef_out
);
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   a_r9_undef_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_wide) |=> !undef_out);

   a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_wide) |=> (res_out[WIDE_W-1:NARROW_W] == '0));

   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_wide && count_in[4:0] == 5'd0) |=>
         (res_out == $past(dst_in) && carry_out == $past(carry_in)));

   a_r2_one_bit_left: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_wide && !op_right && count_in[4:0] == 5'd1) |=>
         (res_out == {$past(dst_in[WIDE_W-2:0]), $past(src_in[WIDE_W-1])}
          && carry_out == $past(dst_in[WIDE_W-1])));
endmodule

bind dps_unit dps_unit_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_wide(op_wide),
   .op_right(op_right), .dst_in(dst_in), .src_in(src_in), .count_in(count_in),
   .carry_in(carry_in), .out_valid(out_valid), .res_out(res_out),
   .carry_out(carry_out), .undef_out(undef_out)
);

// File: tb/dps_unit_test.sv
module dps_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_wide = 1'b0;
   logic        op_right = 1'b0;
   logic [31:0] dst_in = '0;
   logic [31:0] src_in = '0;
   logic [7:0]  count_in = '0;
   logic        carry_in = 1'b0;
   logic        out_valid;
   logic [31:0] res_out;
   logic        carry_out;
   logic        undef_out;

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #4 clk = ~clk;

   dps_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_wide(op_wide),
      .op_right(op_right), .dst_in(dst_in), .src_in(src_in), .count_in(count_in),
      .carry_in(carry_in), .out_valid(out_valid), .res_out(res_out),
      .carry_out(carry_out), .undef_out(undef_out)
   );

   function automatic logic [31:0] next_rnd(logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // Reference: funnel shift of p (shifted) filled from q, width w, count k (0..w-1).
   function automatic logic [31:0] funnel(logic [31:0] p, logic [31:0] q, int w, int k, bit rt);
      logic [31:0] r = '0;
      for (int i = 0; i < w; i++) begin
         if (!rt) r[i] = (i >= k) ? p[i-k] : q[w-k+i];
         else     r[i] = (i + k < w) ? p[i+k] : q[i+k-w];
      end
      return r;
   endfunction

   task automatic check(string req, logic [31:0] er, logic ec, logic eu);
      n_vec++;
      if (out_valid !== 1'b1 || res_out !== er || carry_out !== ec || undef_out !== eu) begin
         n_bad++;
         $display("FAIL %s: got v=%b res=%h c=%b u=%b, expected v=1 res=%h c=%b u=%b",
                  req, out_valid, res_out, carry_out, undef_out, er, ec, eu);
      end
   endtask

   // Drives one operation, waits for the registered result and compares with the model.
   task automatic run(string req, bit wide, bit rt, logic [31:0] d, logic [31:0] s,
                      logic [7:0] cnt, logic ci);
      int c = int'(cnt[4:0]);
      int w = wide ? 32 : 16;
      logic [31:0] dd = wide ? d : {16'h0, d[15:0]};
      logic [31:0] ss = wide ? s : {16'h0, s[15:0]};
      logic [31:0] er;
      logic ec;
      logic eu = (!wide && c > 15);
      if (c == 0) begin
         er = dd; ec = ci;
      end else if (wide || c < 16) begin
         er = funnel(dd, ss, w, c, rt);
         ec = rt ? dd[c-1] : dd[w-c];
      end else begin
         er = funnel(ss, dd, 16, c - 16, rt);
         if (c == 16) ec = rt ? dd[15] : dd[0];
         else         ec = rt ? ss[c-17] : ss[32-c];
      end
      @(negedge clk);
      in_valid = 1'b1; op_wide = wide; op_right = rt;
      dst_in = d; src_in = s; count_in = cnt; carry_in = ci;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, er, ec, eu);
   endtask

   task automatic t_reset;
      n_vec++;
      if (out_valid !== 1'b0 || res_out !== '0 || carry_out !== 1'b0 || undef_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset: got v=%b res=%h c=%b u=%b, expected all zero",
                  out_valid, res_out, carry_out, undef_out);
      end
   endtask

   task automatic t_wide_left;   // R2, R8
      run("R2 fixed", 1, 0, 32'h8000_0001, 32'hF000_0000, 8'd4, 0);
      for (int i = 1; i < 32; i++) begin
         lfsr = next_rnd(lfsr);
         run("R2", 1, 0, lfsr, ~lfsr ^ 32'h1357_9BDF, 8'(i), 0);
      end
   endtask

   task automatic t_wide_right;  // R3, R8
      run("R3 fixed", 1, 1, 32'h0000_0003, 32'h0000_000F, 8'd2, 0);
      for (int i = 1; i < 32; i++) begin
         lfsr = next_rnd(lfsr);
         run("R3", 1, 1, lfsr, {lfsr[15:0], lfsr[31:16]}, 8'(i), 1);
      end
   endtask

   task automatic t_narrow_defined; // R4, R6, R9
      for (int i = 1; i < 16; i++) begin
         lfsr = next_rnd(lfsr);
         run("R4", 0, 0, lfsr, next_rnd(lfsr), 8'(i), 0);
         run("R6", 0, 1, lfsr, next_rnd(lfsr), 8'(i), 1);
      end
      run("R4 edge15", 0, 0, 32'h0000_0001, 32'h0000_FFFE, 8'd15, 0);
   endtask

   task automatic t_narrow_undef; // R5, R8, R9
      run("R5 c16 left", 0, 0, 32'h0000_1234, 32'h0000_ABCD, 8'd16, 0);
      run("R5 c16 right", 0, 1, 32'h0000_1234, 32'h0000_ABCD, 8'd16, 0);
      for (int i = 17; i < 32; i++) begin
         lfsr = next_rnd(lfsr);
         run("R5 left", 0, 0, lfsr, next_rnd(lfsr), 8'(i), 1);
         run("R5 right", 0, 1, lfsr, next_rnd(lfsr), 8'(i), 0);
      end
   endtask

   task automatic t_zero_count;  // R7
      run("R7 wide", 1, 0, 32'hDEAD_BEEF, 32'h1111_1111, 8'd0, 1);
      run("R7 wide rt", 1, 1, 32'hDEAD_BEEF, 32'h1111_1111, 8'd32, 0);
      run("R7 narrow", 0, 1, 32'hFFFF_5A5A, 32'hFFFF_0F0F, 8'd0, 1);
   endtask

   task automatic t_mask;        // R1, R10
      run("R1 mask", 1, 0, 32'h1234_5678, 32'h9ABC_DEF0, 8'hE5, 0);
      run("R1 mask narrow", 0, 1, 32'h0000_8001, 32'h0000_4002, 8'hB3, 1);
      run("R10 upper", 0, 0, 32'hFFFF_00F0, 32'hAAAA_0F00, 8'd4, 0);
      run("R10 upper undef", 0, 0, 32'h5555_00F0, 32'hCCCC_0F00, 8'd20, 0);
   endtask

   task automatic t_hold;        // R11: no load when in_valid is low
      run("R11 load", 1, 0, 32'h0000_00FF, 32'h0, 8'd8, 0);
      @(negedge clk);
      dst_in = 32'h7777_7777; count_in = 8'd3; op_wide = 1'b0;
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || res_out !== 32'h0000_FF00 || carry_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 hold: got v=%b res=%h c=%b, expected v=0 res=0000ff00 c=0",
                  out_valid, res_out, carry_out);
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_wide_left();
      t_wide_right();
      t_narrow_defined();
      t_narrow_undef();
      t_zero_count();
      t_mask();
      t_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule